// File: doc/BRIEF.md
# Multi-channel shadowed PWM generator

This block produces a set of pulse-width-modulated outputs, one per channel, all clocked from a single clock. Software programs each channel's period, high time and start delay through a small word-addressed register bus. Period and high-time writes are staged in shadow storage and do nothing to the outputs until software issues a load command. The load command updates every channel in the same cycle and restarts all running channels from a common instant, so their waveforms stay phase-aligned.

Each running channel counts clock cycles from 0 to period-1 and drives its output high while the count is below the programmed high time. A channel whose committed period is zero is stopped, and its output stays low. A core-wide hold bit, set out of reset, stops every channel and keeps all outputs low until software clears it and issues a load. The bus also offers a fixed identification word, a fixed signature word, a free scratch register and the channel count, which lets software probe the block.

Top module: `pwm_array`

## Requirements
- R1: Reading address 0x0C returns 0x601A3471. Reading address 0x04 returns the `ID_WORD` parameter. Reading address 0x14 returns `NCH`. Writes to these three addresses have no effect.
- R2: The scratch register at 0x08 is 32 bits wide, resets to 0 and reads back the last value written.
- R3: A write to a channel's period (0x40+4n) or high time (0x80+4n) does not change that channel's output until a load command is issued.
- R4: A write to the config register (0x10) with bit 1 = 1 is a load command. In the same clock edge it commits every channel's shadow period and high time. When the written bit 0 is 0, it also restarts every channel with a nonzero period, with the count at 0 in the cycle that follows the edge.
- R5: A running channel repeats a cycle of `period` clock cycles and is high for the first `duty` of them. A duty of 0 gives a constant low output. A duty at or above the period gives a constant high output.
- R6: A channel whose committed period is 0 holds its output low.
- R7: A channel whose start-delay register (0xC0+4n) holds D when it is started stays low for D cycles after the load edge, and only then begins its period at count 0.
- R8: Config bit 0 is the hold bit and resets to 1. While it is 1, all outputs are low and a load does not start any channel. Clearing it does not restart any channel. Channels start only on a later load command.
- R9: A config read returns the hold bit in bit 0 and 0 in bits 31:1. The load bit always reads 0.
- R10: An address that is not mapped reads 0 and ignores writes. Unmapped addresses include misaligned addresses, unused words below 0x40, and channel words at index `NCH` or higher.
- R11: A read of a channel's period, high time or delay register returns the value last written, whether or not that value has been loaded yet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all channels and registers |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register, taken at the rising edge |
| bus_addr | input | 8 | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
On every cycle the assertions check four things: the signature word and the zero upper config bits on reads, zero data on misaligned reads, and all outputs low while hold is set. On every load they also check that a started channel with zero delay and a nonzero high time is high in the next cycle, and that a zero period or a nonzero delay keeps the output low in the next cycle. Other behaviours need the bench's scenarios, which compare a behavioural model against the outputs on every clock. These cover the full waveform shape across several periods, shadowed writes staying invisible until a load, the exact length of a start delay, restart alignment across channels, and register read-back.

// File: rtl/pwm_array_pkg.sv
// Package: shared constants and types for the multi-channel PWM generator.
// Assumes a word-aligned 8-bit byte address space and 32-bit data.
package pwm_array_pkg;
    localparam int DW = 32;
    localparam int AW = 8;

    localparam logic [AW-1:0] A_IDENT   = 8'h04;
    localparam logic [AW-1:0] A_SCRATCH = 8'h08;
    localparam logic [AW-1:0] A_SIGN    = 8'h0C;
    localparam logic [AW-1:0] A_CFG     = 8'h10;
    localparam logic [AW-1:0] A_COUNT   = 8'h14;

    // Channel register banks, selected by address bits 7:6
    localparam logic [1:0] BANK_CTRL = 2'b00;
    localparam logic [1:0] BANK_PER  = 2'b01;
    localparam logic [1:0] BANK_HIGH = 2'b10;
    localparam logic [1:0] BANK_DLY  = 2'b11;

    localparam logic [DW-1:0] SIGN_WORD = 32'h601A3471;

    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_WAIT = 2'b01,
        CH_RUN  = 2'b10
    } ch_mode_t;
endpackage

// File: rtl/pwm_regs.sv
// Register file: decodes the bus, holds the shadow values for every channel,
// the scratch word and the hold bit, and produces the load/start strobes.
// Assumes at most 16 channels, since bits 5:2 of the address select the channel.
module pwm_regs
    import pwm_array_pkg::*;
#(
    parameter int          NCH     = 4,
    parameter logic [31:0] ID_WORD = 32'h0002_0000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    output logic [NCH-1:0][DW-1:0]  sh_period,
    output logic [NCH-1:0][DW-1:0]  sh_duty,
    output logic [NCH-1:0][DW-1:0]  sh_offset,
    output logic                    hold_q,
    output logic                    hold_eff,
    output logic                    load,
    output logic                    start
);
    localparam logic [DW-1:0] COUNT_WORD = DW'(NCH);

    logic [1:0]    bank;
    logic [3:0]    idx;
    logic          aligned;
    logic          cfg_wr;
    logic [DW-1:0] scratch_q;

    assign bank    = bus_addr[7:6];
    assign idx     = bus_addr[5:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cfg_wr  = bus_wr && (bus_addr == A_CFG);

    // Hold value seen by the channels this cycle, including a config write in flight
    assign hold_eff = cfg_wr ? bus_wdata[0] : hold_q;
    // Load strobe, a pulse that is never stored
    assign load     = cfg_wr && bus_wdata[1];
    // Start channels only when the same write leaves hold cleared
    assign start    = load && !bus_wdata[0];

    // Hold bit and scratch word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= 1'b1;
            scratch_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CFG)     hold_q    <= bus_wdata[0];
            if (bus_addr == A_SCRATCH) scratch_q <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_shadow
        // Per-channel shadow registers written at their own word address
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_period[c] <= '0;
                sh_duty[c]   <= '0;
                sh_offset[c] <= '0;
            end else if (bus_wr && aligned && idx == 4'(c)) begin
                case (bank)
                    BANK_PER:  sh_period[c] <= bus_wdata;
                    BANK_HIGH: sh_duty[c]   <= bus_wdata;
                    BANK_DLY:  sh_offset[c] <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // Read multiplexer: unmapped or misaligned addresses return zero
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (bank == BANK_CTRL) begin
                case (bus_addr)
                    A_IDENT:   bus_rdata = ID_WORD;
                    A_SCRATCH: bus_rdata = scratch_q;
                    A_SIGN:    bus_rdata = SIGN_WORD;
                    A_CFG:     bus_rdata = {{(DW-1){1'b0}}, hold_q};
                    A_COUNT:   bus_rdata = COUNT_WORD;
                    default:   bus_rdata = '0;
                endcase
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (idx == 4'(c)) begin
                        case (bank)
                            BANK_PER:  bus_rdata = sh_period[c];
                            BANK_HIGH: bus_rdata = sh_duty[c];
                            default:   bus_rdata = sh_offset[c];
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: holds the committed period and high time, waits out the
// start delay after a load, then counts 0..period-1 and drives the output high
// while the count is below the high time.
// Assumes load/start are single-cycle strobes and hold already includes a
// config write in the same cycle.
module pwm_chan
    import pwm_array_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          start,
    input  logic          hold,
    input  logic [DW-1:0] period_in,
    input  logic [DW-1:0] duty_in,
    input  logic [DW-1:0] offset_in,
    output logic          pwm_o
);
    ch_mode_t      mode;
    logic [DW-1:0] per_q;
    logic [DW-1:0] duty_q;
    logic [DW-1:0] cnt;
    logic [DW-1:0] wait_cnt;

    // Commit, restart, delay and count sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= CH_IDLE;
            per_q    <= '0;
            duty_q   <= '0;
            cnt      <= '0;
            wait_cnt <= '0;
        end else if (load) begin
            per_q    <= period_in;
            duty_q   <= duty_in;
            cnt      <= '0;
            wait_cnt <= offset_in;
            if (start && period_in != '0)
                mode <= (offset_in == '0) ? CH_RUN : CH_WAIT;
            else
                mode <= CH_IDLE;
        end else if (hold) begin
            mode <= CH_IDLE;
        end else begin
            case (mode)
                CH_WAIT: begin
                    if (wait_cnt == DW'(1)) begin
                        mode <= CH_RUN;
                        cnt  <= '0;
                    end else begin
                        wait_cnt <= wait_cnt - DW'(1);
                    end
                end
                CH_RUN:  cnt <= (cnt >= per_q - DW'(1)) ? '0 : cnt + DW'(1);
                default: ;
            endcase
        end
    end

    // Output is high only while running and inside the high-time window
    assign pwm_o = (mode == CH_RUN) && (cnt < duty_q);
endmodule

// File: rtl/pwm_array.sv
// Top: register file plus one PWM channel per output.
// Assumes 1 <= NCH <= 16 and a single clock domain.
module pwm_array
    import pwm_array_pkg::*;
#(
    parameter int          NCH     = 4,
    parameter logic [31:0] ID_WORD = 32'h0002_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    logic [NCH-1:0][DW-1:0] sh_period;
    logic [NCH-1:0][DW-1:0] sh_duty;
    logic [NCH-1:0][DW-1:0] sh_offset;
    logic                   hold_q;
    logic                   hold_eff;
    logic                   load;
    logic                   start;

    pwm_regs #(.NCH(NCH), .ID_WORD(ID_WORD)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sh_period (sh_period),
        .sh_duty   (sh_duty),
        .sh_offset (sh_offset),
        .hold_q    (hold_q),
        .hold_eff  (hold_eff),
        .load      (load),
        .start     (start)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pwm_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .start     (start),
            .hold      (hold_eff),
            .period_in (sh_period[c]),
            .duty_in   (sh_duty[c]),
            .offset_in (sh_offset[c]),
            .pwm_o     (pwm_out[c])
        );
    end
endmodule

// File: rtl/pwm_array_chk.sv
// Checker for pwm_array: port and strobe relations that hold on every cycle.
module pwm_array_chk
    import pwm_array_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [7:0]             bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NCH-1:0][DW-1:0] sh_period,
    input logic [NCH-1:0][DW-1:0] sh_duty,
    input logic [NCH-1:0][DW-1:0] sh_offset,
    input logic                   hold_q,
    input logic                   load,
    input logic                   start,
    input logic [NCH-1:0]         pwm_out
);
    AST_SIGN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_SIGN) |-> (bus_rdata == SIGN_WORD)); // R1
    AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CFG) |-> (bus_rdata[31:1] == '0)); // R9
    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R10
    AST_HOLD_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (pwm_out == '0)); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (start && sh_period[c] != '0 && sh_offset[c] == '0 && sh_duty[c] != '0)
            |=> pwm_out[c]); // R4
        AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (load && sh_period[c] == '0) |=> !pwm_out[c]); // R6
        AST_DELAY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (start && sh_offset[c] != '0) |=> !pwm_out[c]); // R7
    end
endmodule

bind pwm_array pwm_array_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_pwm_array.sv
// Bench: behavioural reference model compared against pwm_out on every clock,
// plus register read checks.
module sim_pwm_array;
    localparam int NCH = 3;
    localparam logic [31:0] IDW = 32'h0002_0100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;

    int    vectors = 0;
    int    miscompares = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R8";

    pwm_array #(.NCH(NCH), .ID_WORD(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    // Reference model state
    logic [31:0] m_per [NCH];
    logic [31:0] m_duty[NCH];
    logic [31:0] m_ofs [NCH];
    logic [31:0] m_scr;
    bit          m_hold;
    longint      a_per [NCH];
    longint      a_duty[NCH];
    longint      pos   [NCH];  // -1 idle, <-1 remaining delay, >=0 phase
    bit          ld, st, he;

    // Model update on each rising edge from the stable bus inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_scr = 0; m_hold = 1;
            for (int c = 0; c < NCH; c++) begin
                m_per[c] = 0; m_duty[c] = 0; m_ofs[c] = 0;
                a_per[c] = 0; a_duty[c] = 0; pos[c] = -1;
            end
        end else begin
            ld = bus_wr && bus_addr == 8'h10 && bus_wdata[1];
            st = ld && !bus_wdata[0];
            he = (bus_wr && bus_addr == 8'h10) ? bus_wdata[0] : m_hold;
            for (int c = 0; c < NCH; c++) begin
                if (ld) begin
                    a_per[c] = m_per[c]; a_duty[c] = m_duty[c];
                    if (st && m_per[c] != 0) pos[c] = -longint'(m_ofs[c]);
                    else pos[c] = -1;
                    if (pos[c] < 0 && st && m_per[c] != 0) pos[c] = pos[c] - 1;
                end else if (he) begin
                    pos[c] = -1;
                end else if (pos[c] < -1) begin
                    pos[c] = (pos[c] == -2) ? 0 : pos[c] + 1;
                end else if (pos[c] >= 0) begin
                    pos[c] = (pos[c] + 1) % a_per[c];
                end
            end
            if (bus_wr && bus_addr[1:0] == 2'b00) begin
                if (bus_addr == 8'h08) m_scr = bus_wdata;
                if (bus_addr == 8'h10) m_hold = bus_wdata[0];
                if (bus_addr[7:6] != 2'b00 && int'(bus_addr[5:2]) < NCH) begin
                    case (bus_addr[7:6])
                        2'b01:   m_per [bus_addr[5:2]] = bus_wdata;
                        2'b10:   m_duty[bus_addr[5:2]] = bus_wdata;
                        default: m_ofs [bus_addr[5:2]] = bus_wdata;
                    endcase
                end
            end
        end
    end

    function automatic bit exp_out(int c);
        return (pos[c] >= 0) && (pos[c] < a_duty[c]);
    endfunction

    // Output comparison every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                vectors++;
                if (pwm_out[c] !== exp_out(c)) begin
                    miscompares++;
                    $display("FAIL %s: ch%0d pwm_out=%b expected %b at cycle %0d",
                             cur_req, c, pwm_out[c], exp_out(c), cyc);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #2;
        vectors++;
        if (bus_rdata !== exp) begin
            miscompares++;
            $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state and fixed words
        cur_req = "R8";
        rd(8'h10, 32'h1, "R8");
        rd(8'h0C, 32'h601A3471, "R1");
        rd(8'h04, IDW, "R1");
        rd(8'h14, 32'd3, "R1");
        rd(8'h08, 32'h0, "R2");

        // Scratch, read-only words and unmapped space
        wr(8'h08, 32'hA5A5_5A5A);
        rd(8'h08, 32'hA5A5_5A5A, "R2");
        wr(8'h0C, 32'h1234_5678);
        rd(8'h0C, 32'h601A3471, "R1");
        wr(8'h14, 32'h99);
        rd(8'h14, 32'd3, "R1");
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R10");
        wr(8'h4C, 32'h77);
        rd(8'h4C, 32'h0, "R10");
        rd(8'hCC, 32'h0, "R10");
        rd(8'h09, 32'h0, "R10");
        rd(8'h10, 32'h1, "R9");

        // Program channels; hold keeps outputs low even through a load
        cur_req = "R11";
        wr(8'h40, 32'd5);  wr(8'h80, 32'd2);
        wr(8'h44, 32'd4);  wr(8'h84, 32'd4);
        wr(8'h48, 32'd6);  wr(8'h88, 32'd0);
        rd(8'h40, 32'd5, "R11");
        rd(8'h84, 32'd4, "R11");
        cur_req = "R8";
        wr(8'h10, 32'h3);
        idle(6);
        rd(8'h10, 32'h1, "R9");

        // Clear hold and load: synchronous start
        cur_req = "R4";
        wr(8'h10, 32'h2);
        cur_req = "R5";
        idle(20);
        rd(8'h10, 32'h0, "R9");

        // Shadowed write has no effect until load
        cur_req = "R3";
        wr(8'h80, 32'd4);
        rd(8'h80, 32'd4, "R11");
        idle(12);
        cur_req = "R4";
        wr(8'h10, 32'h2);
        idle(15);

        // Start delays
        cur_req = "R7";
        wr(8'hC4, 32'd3);
        wr(8'h48, 32'd7); wr(8'h88, 32'd3); wr(8'hC8, 32'd5);
        rd(8'hC8, 32'd5, "R11");
        wr(8'h10, 32'h2);
        idle(25);

        // Zero period stops a channel
        cur_req = "R6";
        wr(8'h40, 32'd0);
        wr(8'h10, 32'h2);
        idle(10);

        // Duty far above period: constant high
        cur_req = "R5";
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h10, 32'h2);
        idle(12);

        // Hold forces low; clearing hold alone does not restart
        cur_req = "R8";
        wr(8'h10, 32'h1);
        idle(5);
        rd(8'h10, 32'h1, "R9");
        wr(8'h10, 32'h0);
        idle(6);
        cur_req = "R4";
        wr(8'h10, 32'h2);
        idle(12);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule